// File: doc/BRIEF.md
# DRAM Bank State Timing Tracker

This block sits in the command path of a DDR2-style SDRAM controller. It follows the open or closed state of each internal bank and decides, in the same cycle a command is presented, whether that command may issue now. ACTIVATE opens a bank on a row. READ and WRITE carry a starting column and an auto-precharge flag in address bit 10. PRECHARGE closes a bank. The block enforces four row-cycle limits per bank: activate-to-column (tRCD), activate-to-precharge (tRAS), precharge-to-activate (tRP) and activate-to-activate (tRC).

Every limit comes from a configuration input and is given in clock cycles. The controller rounds each nanosecond figure up to whole cycles before loading it, so 15 ns at a 3.75 ns clock becomes 4. A fifth count gives the burst duration used for auto-precharge. Each bank runs its own down-counters, so commands to different banks are checked independently. A command that breaks the bank protocol is rejected and sets a sticky violation flag. A command that is only early is stalled and does not set the flag.

Top module: `bank_timing_tracker`

## Requirements
- R1: While reset is asserted and after it is released, all banks are closed, every open-row field reads 0 and the violation flag is 0.
- R2: When an ACTIVATE (cmd=1) reaches an idle bank whose tRP and tRC windows have expired, it is accepted in that cycle. From the next cycle, bankOpen[bank] is 1 and the bank's 13-bit openRows field (bits bank*13 and up) holds cmdAddr. The field keeps that value until the next accepted ACTIVATE to the same bank.
- R3: A READ (cmd=2) or WRITE (cmd=3) to an open bank is stalled until tRCD cycles have passed since that bank's ACTIVATE. With the ACTIVATE in cycle t, the command is first accepted in cycle t+tRCD.
- R4: A PRECHARGE (cmd=4) to an open bank is stalled until cycle t+tRAS, where t is the cycle of that bank's ACTIVATE. Once accepted, it closes the bank from the next cycle. A PRECHARGE to a bank that is not open is accepted and changes no state.
- R5: An ACTIVATE to an idle bank is accepted no earlier than cycle p+tRP and no earlier than cycle a+tRC. Here p is the cycle of the bank's last precharge and a is the cycle of its last ACTIVATE.
- R6: A READ or WRITE with cmdAddr bit 10 set is an auto-precharge access. From the next cycle it reports the bank closed. The internal precharge happens in cycle p, the later of (command cycle + tBurst) and (ACTIVATE cycle + tRAS). Until then an ACTIVATE to that bank is stalled without a violation, and R5 then applies from p.
- R7: A READ or WRITE to a bank that is not open, or an ACTIVATE to an open bank, is rejected (cmdAccept=0, cmdStall=1). From the next cycle the violation flag is 1, and it stays 1 until reset.
- R8: Commands to one bank are accepted while another bank's timing windows are still running.
- R9: NOP (cmd=0) and the unused codes 5 to 7 give cmdAccept=0 and cmdStall=0 and change no state. For every other code exactly one of cmdAccept and cmdStall is 1.
- R10: A configured count of 0 behaves as 1: the dependent command may issue in the cycle right after the command that started the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE |
| cmdBank | input | 2 | Target bank |
| cmdAddr | input | 13 | Row for ACTIVATE; column plus auto-precharge at bit 10 for READ/WRITE |
| cfgTrcd | input | 6 | Activate-to-column limit, cycles |
| cfgTras | input | 6 | Activate-to-precharge limit, cycles |
| cfgTrp | input | 6 | Precharge-to-activate limit, cycles |
| cfgTrc | input | 6 | Activate-to-activate limit, cycles |
| cfgTburst | input | 6 | Burst duration before auto-precharge, cycles |
| cmdAccept | output | 1 | Current command is legal and takes effect at this edge |
| cmdStall | output | 1 | Current command is not accepted this cycle |
| bankOpen | output | 4 | One bit per bank, 1 while open |
| openRows | output | 52 | Open row per bank, 13 bits each, bank 0 lowest |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
cmdAccept and cmdStall are combinational and are due in the same cycle as the command. bankOpen, openRows and violation change at the clock edge that ends the accepting or rejected cycle, so they are due one cycle later. The bench drives each command on the falling edge and samples all outputs 1 ns later. At that point it reads the accept/stall decision for the current command together with the bank state left by the previous one. Each vector's expected bankOpen is therefore the state after the previous command, and each expected accept cycle is counted from the ACTIVATE, PRECHARGE or auto-precharge cycle named in the requirements.

// File: rtl/bank_track_pkg.sv
`timescale 1ns/1ps
package bank_track_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2
  } bank_st_e;

  // strobes from control to datapath, one set per bank
  typedef struct packed {
    logic act;
    logic col;
    logic apStart;
    logic pre;
  } bank_strb_t;

  // window-expired flags from datapath to control, one set per bank
  typedef struct packed {
    logic rcd;
    logic ras;
    logic rp;
    logic rc;
    logic burst;
  } bank_rdy_t;
endpackage

// File: rtl/bank_down_counter.sv
`timescale 1ns/1ps
module bank_down_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  // a limit of N lets the dependent command go N cycles after the load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (limit == '0) ? '0 : limit - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/bank_track_timers.sv
`timescale 1ns/1ps
module bank_track_timers
  import bank_track_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  parameter int CNT_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [CNT_W-1:0]           cfgTrcd,
  input  logic [CNT_W-1:0]           cfgTras,
  input  logic [CNT_W-1:0]           cfgTrp,
  input  logic [CNT_W-1:0]           cfgTrc,
  input  logic [CNT_W-1:0]           cfgTburst,
  input  logic [ROW_W-1:0]           actRow,
  input  bank_strb_t [NB-1:0]        strb,
  output bank_rdy_t  [NB-1:0]        rdy,
  output logic [NB-1:0][ROW_W-1:0]   openRow
);
  logic [NB-1:0] actVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openRow <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (strb[b].act) openRow[b] <= actRow;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic rcdDone, rasDone, rpDone, rcDone, burstDone;

    assign actVec[b] = strb[b].act;

    bank_down_counter #(.CNT_W(CNT_W)) i_rcd (
      .clk(clk), .rstN(rstN), .load(strb[b].act), .limit(cfgTrcd), .done(rcdDone));
    bank_down_counter #(.CNT_W(CNT_W)) i_ras (
      .clk(clk), .rstN(rstN), .load(strb[b].act), .limit(cfgTras), .done(rasDone));
    bank_down_counter #(.CNT_W(CNT_W)) i_rc (
      .clk(clk), .rstN(rstN), .load(strb[b].act), .limit(cfgTrc), .done(rcDone));
    bank_down_counter #(.CNT_W(CNT_W)) i_rp (
      .clk(clk), .rstN(rstN), .load(strb[b].pre), .limit(cfgTrp), .done(rpDone));
    bank_down_counter #(.CNT_W(CNT_W)) i_burst (
      .clk(clk), .rstN(rstN), .load(strb[b].apStart), .limit(cfgTburst), .done(burstDone));

    assign rdy[b] = {rcdDone, rasDone, rpDone, rcDone, burstDone};

    AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rstN)
      strb[b].col |-> rcdDone);                                              // R3
    AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rstN)
      strb[b].pre |-> rasDone);                                              // R4
    AST_ACT_AFTER_RP_RC: assert property (@(posedge clk) disable iff (!rstN)
      strb[b].act |-> (rpDone && rcDone));                                   // R5
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rstN)
      !strb[b].act |=> $stable(openRow[b]));                                 // R2
  end

  AST_ONE_ACT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(actVec));                                                       // R8
endmodule

// File: rtl/bank_track_ctrl.sv
`timescale 1ns/1ps
module bank_track_ctrl
  import bank_track_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cmd,
  input  logic [BA_W-1:0]     cmdBank,
  input  logic                cmdAp,
  input  bank_rdy_t [NB-1:0]  rdy,
  output bank_strb_t [NB-1:0] strb,
  output logic                cmdAccept,
  output logic                cmdStall,
  output logic [NB-1:0]       bankOpen,
  output logic                violation
);
  bank_st_e  bankSt  [NB];
  bank_st_e  bankNxt [NB];
  bank_st_e  selSt;
  bank_rdy_t selRdy;
  logic      isCmd, illegal;
  logic [NB-1:0] autoFire;

  always_comb begin
    selSt     = bankSt[cmdBank];
    selRdy    = rdy[cmdBank];
    isCmd     = 1'b0;
    cmdAccept = 1'b0;
    illegal   = 1'b0;
    case (cmd)
      CMD_ACT: begin
        isCmd     = 1'b1;
        cmdAccept = (selSt == BK_IDLE) && selRdy.rp && selRdy.rc;
        illegal   = (selSt == BK_OPEN);
      end
      CMD_RD, CMD_WR: begin
        isCmd     = 1'b1;
        cmdAccept = (selSt == BK_OPEN) && selRdy.rcd;
        illegal   = (selSt != BK_OPEN);
      end
      CMD_PRE: begin
        isCmd     = 1'b1;
        cmdAccept = (selSt != BK_OPEN) || selRdy.ras;
      end
      default: ;
    endcase
    cmdStall = isCmd && !cmdAccept;
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      logic hit;
      hit = (cmdBank == BA_W'(b));
      autoFire[b]       = (bankSt[b] == BK_CLOSING) && rdy[b].ras && rdy[b].burst;
      strb[b].act       = cmdAccept && hit && (cmd == CMD_ACT);
      strb[b].col       = cmdAccept && hit && ((cmd == CMD_RD) || (cmd == CMD_WR));
      strb[b].apStart   = strb[b].col && cmdAp;
      strb[b].pre       = (cmdAccept && hit && (cmd == CMD_PRE) && (bankSt[b] == BK_OPEN))
                          || autoFire[b];
      bankNxt[b] = bankSt[b];
      if (strb[b].act)          bankNxt[b] = BK_OPEN;
      else if (strb[b].apStart) bankNxt[b] = BK_CLOSING;
      else if (strb[b].pre)     bankNxt[b] = BK_IDLE;
      bankOpen[b] = (bankSt[b] == BK_OPEN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++) bankSt[b] <= BK_IDLE;
      violation <= 1'b0;
    end else begin
      for (int b = 0; b < NB; b++) bankSt[b] <= bankNxt[b];
      if (illegal) violation <= 1'b1;
    end
  end

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);                                                // R7
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_NOP) |=> $stable(bankOpen));                                 // R9

  for (genvar b = 0; b < NB; b++) begin : g_chk
    AST_OPEN_FROM_ACT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(bankOpen[b]) |-> ($past(cmd) == CMD_ACT && $past(cmdBank) == BA_W'(b))); // R2
    AST_CLOSED_AFTER_PRE: assert property (@(posedge clk) disable iff (!rstN)
      strb[b].pre |=> !bankOpen[b]);                                         // R4
  end
endmodule

// File: rtl/bank_timing_tracker.sv
`timescale 1ns/1ps
module bank_timing_tracker
  import bank_track_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 13,
  parameter int CNT_W  = 6,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cmd,
  input  logic [BA_W-1:0]     cmdBank,
  input  logic [ROW_W-1:0]    cmdAddr,
  input  logic [CNT_W-1:0]    cfgTrcd,
  input  logic [CNT_W-1:0]    cfgTras,
  input  logic [CNT_W-1:0]    cfgTrp,
  input  logic [CNT_W-1:0]    cfgTrc,
  input  logic [CNT_W-1:0]    cfgTburst,
  output logic                cmdAccept,
  output logic                cmdStall,
  output logic [NB-1:0]       bankOpen,
  output logic [NB*ROW_W-1:0] openRows,
  output logic                violation
);
  bank_strb_t [NB-1:0]      strb;
  bank_rdy_t  [NB-1:0]      rdy;
  logic [NB-1:0][ROW_W-1:0] openRowArr;

  bank_track_ctrl #(.NB(NB), .BA_W(BA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdBank(cmdBank),
    .cmdAp(cmdAddr[AP_BIT]), .rdy(rdy), .strb(strb),
    .cmdAccept(cmdAccept), .cmdStall(cmdStall),
    .bankOpen(bankOpen), .violation(violation));

  bank_track_timers #(.NB(NB), .ROW_W(ROW_W), .CNT_W(CNT_W)) i_timers (
    .clk(clk), .rstN(rstN),
    .cfgTrcd(cfgTrcd), .cfgTras(cfgTras), .cfgTrp(cfgTrp),
    .cfgTrc(cfgTrc), .cfgTburst(cfgTburst),
    .actRow(cmdAddr), .strb(strb), .rdy(rdy), .openRow(openRowArr));

  assign openRows = openRowArr;
endmodule

// File: tb/test_bank_timing_tracker.sv
`timescale 1ns/1ps
module test_bank_timing_tracker;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  cmd;
  logic [1:0]  cmdBank;
  logic [12:0] cmdAddr;
  logic [5:0]  cfgTrcd, cfgTras, cfgTrp, cfgTrc, cfgTburst;
  logic        cmdAccept, cmdStall, violation;
  logic [3:0]  bankOpen;
  logic [51:0] openRows;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bank_timing_tracker i_bank_timing_tracker (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .cfgTrcd(cfgTrcd), .cfgTras(cfgTras), .cfgTrp(cfgTrp), .cfgTrc(cfgTrc),
    .cfgTburst(cfgTburst), .cmdAccept(cmdAccept), .cmdStall(cmdStall),
    .bankOpen(bankOpen), .openRows(openRows), .violation(violation));

  // {req[3:0], cmd[2:0], bank[1:0], addr[12:0], acc, stall, expOpen[3:0]}
  // trcd=3 tras=8 trp=3 trc=12 tburst=2; one vector per cycle from cycle 0
  localparam logic [27:0] VEC [22] = '{
    {4'd2, 3'd1, 2'd0, 13'h0123, 1'b1, 1'b0, 4'h0},  // c0 ACT b0
    {4'd3, 3'd2, 2'd0, 13'h0000, 1'b0, 1'b1, 4'h1},  // c1 early RD
    {4'd3, 3'd2, 2'd0, 13'h0000, 1'b0, 1'b1, 4'h1},  // c2
    {4'd3, 3'd2, 2'd0, 13'h0004, 1'b1, 1'b0, 4'h1},  // c3 RD at t+trcd
    {4'd8, 3'd1, 2'd1, 13'h00AA, 1'b1, 1'b0, 4'h1},  // c4 ACT b1
    {4'd4, 3'd4, 2'd0, 13'h0000, 1'b0, 1'b1, 4'h3},  // c5 early PRE b0
    {4'd8, 3'd2, 2'd1, 13'h0000, 1'b0, 1'b1, 4'h3},  // c6 early RD b1
    {4'd8, 3'd3, 2'd1, 13'h0008, 1'b1, 1'b0, 4'h3},  // c7 WR b1
    {4'd4, 3'd4, 2'd0, 13'h0000, 1'b1, 1'b0, 4'h3},  // c8 PRE b0 at t+tras
    {4'd5, 3'd1, 2'd0, 13'h0055, 1'b0, 1'b1, 4'h2},  // c9 trp pending
    {4'd5, 3'd1, 2'd0, 13'h0055, 1'b0, 1'b1, 4'h2},  // c10
    {4'd5, 3'd1, 2'd0, 13'h0055, 1'b0, 1'b1, 4'h2},  // c11 trp met, trc not
    {4'd5, 3'd1, 2'd0, 13'h0055, 1'b1, 1'b0, 4'h2},  // c12 ACT b0 again
    {4'd9, 3'd0, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h3},  // c13 NOP
    {4'd9, 3'd6, 2'd1, 13'h1FFF, 1'b0, 1'b0, 4'h3},  // c14 unused code
    {4'd6, 3'd2, 2'd1, 13'h0400, 1'b1, 1'b0, 4'h3},  // c15 RD b1 auto-pre
    {4'd6, 3'd1, 2'd1, 13'h01FF, 1'b0, 1'b1, 4'h1},  // c16 closing
    {4'd6, 3'd1, 2'd1, 13'h01FF, 1'b0, 1'b1, 4'h1},  // c17 precharge here
    {4'd6, 3'd1, 2'd1, 13'h01FF, 1'b0, 1'b1, 4'h1},  // c18
    {4'd6, 3'd1, 2'd1, 13'h01FF, 1'b0, 1'b1, 4'h1},  // c19
    {4'd6, 3'd1, 2'd1, 13'h01FF, 1'b1, 1'b0, 4'h1},  // c20 ACT b1 at p+trp
    {4'd4, 3'd4, 2'd2, 13'h0000, 1'b1, 1'b0, 4'h3}   // c21 PRE idle b2
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [2:0] c, logic [1:0] b, logic [12:0] a);
    @(negedge clk);
    cmd = c; cmdBank = b; cmdAddr = a;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cmd = 3'd0; cmdBank = 2'd0; cmdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; cmd = 3'd0; cmdBank = 2'd0; cmdAddr = '0;
    cfgTrcd = 6'd3; cfgTras = 6'd8; cfgTrp = 6'd3; cfgTrc = 6'd12; cfgTburst = 6'd2;
    repeat (3) @(negedge clk);
    #1;
    check("R1 open during reset", bankOpen, 4'h0);
    check("R1 viol during reset", violation, 1'b0);
    rstN = 1'b1;
    #1;
    check("R1 rows after reset", openRows, 52'h0);

    for (int i = 0; i < 22; i++) begin
      logic [27:0] v;
      v = VEC[i];
      step(v[23:21], v[20:19], v[18:6]);
      check($sformatf("R%0d c%0d open", v[27:24], i), bankOpen, v[3:0]);
      check($sformatf("R%0d c%0d accept", v[27:24], i), cmdAccept, v[5]);
      check($sformatf("R%0d c%0d stall", v[27:24], i), cmdStall, v[4]);
    end

    step(3'd2, 2'd3, 13'h0000);   // R7 read to closed bank 3
    check("R2 open after walk", bankOpen, 4'h3);
    check("R2 row b0", openRows[12:0], 13'h0055);
    check("R6 row b1", openRows[25:13], 13'h01FF);
    check("R8 no violation yet", violation, 1'b0);
    check("R7 closed RD accept", cmdAccept, 1'b0);
    check("R7 closed RD stall", cmdStall, 1'b1);
    step(3'd1, 2'd0, 13'h0AAA);   // R7 ACT to open bank 0
    check("R7 violation set", violation, 1'b1);
    check("R7 ACT open bank stall", cmdStall, 1'b1);
    step(3'd1, 2'd3, 13'h00F0);
    check("R7 row b0 untouched", openRows[12:0], 13'h0055);
    check("R2 ACT b3 accept", cmdAccept, 1'b1);
    step(3'd0, 2'd0, 13'h0000);
    check("R7 violation sticky", violation, 1'b1);
    check("R2 row b3", openRows[51:39], 13'h00F0);

    doReset();
    #1;
    check("R1 open after reset", bankOpen, 4'h0);
    check("R1 viol cleared", violation, 1'b0);
    check("R1 rows cleared", openRows, 52'h0);

    // R10 zero counts
    cfgTrcd = 6'd0; cfgTras = 6'd0; cfgTrp = 6'd0; cfgTrc = 6'd0; cfgTburst = 6'd0;
    step(3'd1, 2'd2, 13'h0005);
    check("R10 ACT accept", cmdAccept, 1'b1);
    step(3'd3, 2'd2, 13'h0000);
    check("R10 WR next cycle", cmdAccept, 1'b1);
    step(3'd4, 2'd2, 13'h0000);
    check("R10 PRE next cycle", cmdAccept, 1'b1);
    step(3'd1, 2'd2, 13'h0006);
    check("R10 ACT after PRE", cmdAccept, 1'b1);
    step(3'd0, 2'd0, 13'h0000);
    check("R10 row b2", openRows[38:26], 13'h0006);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule